// File: doc/BRIEF.md
# Periodic Limit Timer

This block is an interval timer for a system tick. A counter steps up once on each qualifying tick pulse and moves toward a programmed limit. When the next step would reach the limit, the counter goes back to 1, not to 0. At the same time a sticky limit-reached flag is set, and that flag drives a level interrupt request. With a limit of N+1 the timer fires once every N ticks. An external prescaler supplies the tick pulse, at one microsecond per pulse in the default resolution or half a microsecond per pulse in the fine resolution.

Software reaches the timer through a single-cycle register port. Each access is either a read or a write. Three addresses are in use. The first is a limit address that loads the limit and restarts the count. The second is a read-only counter address. The third is a second limit address that loads the limit but leaves the count running. In every word, bit 31 carries the flag and the count field sits just below it. The field is 21 bits at bit 10 in the default resolution and 22 bits at bit 9 in the fine resolution. The bits below the field read as zero. Read data appears one clock after the read access.

Top module: `lim_tick_timer`

## Requirements
- R1: After reset, the counter reads as 1, the limit reads as 0, the flag is clear and `irq_o` is low.
- R2: With a limit L greater than 1, successive ticks take the counter through 1, 2, ..., L-1 and then back to 1. A limit of 4 gives 1, 2, 3, 1. With a limit of 2, every tick returns the counter to 1 and sets the flag.
- R3: The tick that returns the counter to 1 sets the flag, which appears in bit 31 of every read word, and drives `irq_o` high from the following cycle.
- R4: Reading address 0 returns {flag, limit, zeros}, with the limit in bits 30:10 in the default resolution. That read clears the flag and `irq_o`. The bits below the field always read as zero.
- R5: Writing address 0 loads the limit from bits 30:10 of the write data and restarts the counter at 1.
- R6: Writing address 2 loads the limit but leaves the counter unchanged. If the count is then at or beyond the new limit, the next tick returns the counter to 1 and sets the flag.
- R7: While the limit is 0, ticks leave the counter unchanged.
- R8: Address 1 returns {flag, counter, zeros}. A write to address 1 changes neither the counter nor the limit.
- R9: A tick that arrives in the same cycle as any register write is dropped.
- R10: If the counter wraps in the same cycle as a clearing read of address 0, the flag stays set. A flag that is already set stays set through further wraps, and one clearing read clears it.
- R11: Reading address 2 returns the same word as address 0 but does not clear the flag.
- R12: Address 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse, one time unit |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| irq_o | output | 1 | Limit-reached interrupt request |

## Verification
The hardest case to reach is a wrap that lands in the same cycle as the clearing read of the limit address. The flag must survive that collision. The bench first counts the timer up to one tick short of its limit. It then drives a tick and a limit read on the same clock edge. It expects the read word to show the old, clear flag and expects the interrupt to be high in the next cycle. The bench reaches the case of a count beyond the limit by lowering the limit below the running count through the non-restarting address.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Register addresses; the restart/keep split is behavioural.
   typedef enum logic [1:0] {
      REG_LIM      = 2'd0,
      REG_CNT      = 2'd1,
      REG_LIM_KEEP = 2'd2,
      REG_NONE     = 2'd3
   } tmr_reg_e;

   // Decoded per-cycle controls.
   typedef struct packed {
      logic ld_restart;   // limit load that restarts the count
      logic ld_keep;      // limit load that keeps the count
      logic wr_any;       // any write access (blocks a tick)
      logic rd_clear;     // read that clears the flag
   } tmr_ctl_t;

   function automatic int unsigned cnt_width(input bit fine);
      return fine ? 22 : 21;
   endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
   import tmr_pkg::*;
(
   input  logic     sel_i,
   input  logic     wr_i,
   input  tmr_reg_e addr_i,
   output tmr_ctl_t ctl_o
);

   always_comb begin
      ctl_o            = '0;
      ctl_o.wr_any     = sel_i && wr_i;
      ctl_o.ld_restart = sel_i && wr_i && (addr_i == REG_LIM);
      ctl_o.ld_keep    = sel_i && wr_i && (addr_i == REG_LIM_KEEP);
      ctl_o.rd_clear   = sel_i && !wr_i && (addr_i == REG_LIM);
   end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_pkg::*;
#(
   parameter int CNT_W = 21
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  tmr_ctl_t         ctl_i,
   input  logic [CNT_W-1:0] wr_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] lim_o,
   output logic             flag_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("tmr_count_core: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, lim_q;
   logic             flag_q;
   logic [CNT_W:0]   nxt_w;
   logic             adv_w, hit_w;

   assign nxt_w = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
   assign adv_w = tick_i && !ctl_i.wr_any && (lim_q != '0);
   assign hit_w = adv_w && (nxt_w >= {1'b0, lim_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_ONE;
         lim_q <= '0;
      end else if (ctl_i.ld_restart) begin
         lim_q <= wr_val_i;
         cnt_q <= CNT_ONE;
      end else if (ctl_i.ld_keep) begin
         lim_q <= wr_val_i;
      end else if (adv_w) begin
         cnt_q <= hit_w ? CNT_ONE : nxt_w[CNT_W-1:0];
      end
   end

   // Set has priority over a clearing read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              flag_q <= 1'b0;
      else if (hit_w)          flag_q <= 1'b1;
      else if (ctl_i.rd_clear) flag_q <= 1'b0;
   end

   assign cnt_o  = cnt_q;
   assign lim_o  = lim_q;
   assign flag_o = flag_q;
   assign wrap_o = hit_w;

   p_cnt_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lim_q == '0 && !ctl_i.ld_restart) |=> cnt_q == $past(cnt_q));

   p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.ld_restart |=> (cnt_q == CNT_ONE && lim_q == $past(wr_val_i)));

   p_keep_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_i.ld_keep |=> (lim_q == $past(wr_val_i) && $stable(cnt_q)));

   p_write_drops_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && ctl_i.wr_any && !ctl_i.ld_restart) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_read_port.sv
module tmr_read_port
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 21
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  tmr_reg_e          addr_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [CNT_W-1:0]  lim_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int LSB = DATA_W - 1 - CNT_W;

   if (LSB < 0) begin : g_bad_fit
      $error("tmr_read_port: count field does not fit in DATA_W");
   end

   logic [DATA_W-1:0] cnt_word, lim_word, rdata_q;

   if (LSB > 0) begin : g_pad
      assign cnt_word = {flag_i, cnt_i, {LSB{1'b0}}};
      assign lim_word = {flag_i, lim_i, {LSB{1'b0}}};

      p_low_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
         rdata_q[LSB-1:0] == '0);
   end else begin : g_nopad
      assign cnt_word = {flag_i, cnt_i};
      assign lim_word = {flag_i, lim_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_i) begin
         unique case (addr_i)
            REG_LIM, REG_LIM_KEEP: rdata_q <= lim_word;
            REG_CNT:               rdata_q <= cnt_word;
            default:               rdata_q <= '0;
         endcase
      end
   end

   assign rdata_o = rdata_q;

   p_dead_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && addr_i == REG_NONE) |=> rdata_q == '0);

endmodule

// File: rtl/lim_tick_timer.sv
module lim_tick_timer
   import tmr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit FINE_RES = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   localparam int CNT_W = cnt_width(FINE_RES);
   localparam int LSB   = DATA_W - 1 - CNT_W;

   if (LSB < 0) begin : g_bad_data_w
      $error("lim_tick_timer: DATA_W too small for the count field");
   end

   tmr_reg_e         addr_w;
   tmr_ctl_t         ctl_w;
   logic [CNT_W-1:0] wr_val_w, cnt_w, lim_w;
   logic             flag_w, wrap_w, rd_w;

   assign addr_w   = tmr_reg_e'(bus_addr_i);
   assign wr_val_w = bus_wdata_i[LSB +: CNT_W];
   assign rd_w     = bus_sel_i && !bus_wr_i;

   tmr_bus_decode u_dec (
      .sel_i  (bus_sel_i),
      .wr_i   (bus_wr_i),
      .addr_i (addr_w),
      .ctl_o  (ctl_w)
   );

   tmr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i),
      .ctl_i    (ctl_w),
      .wr_val_i (wr_val_w),
      .cnt_o    (cnt_w),
      .lim_o    (lim_w),
      .flag_o   (flag_w),
      .wrap_o   (wrap_w)
   );

   tmr_read_port #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_i    (rd_w),
      .addr_i  (addr_w),
      .cnt_i   (cnt_w),
      .lim_i   (lim_w),
      .flag_i  (flag_w),
      .rdata_o (bus_rdata_o)
   );

   assign irq_o = flag_w;

   p_wrap_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_w |=> irq_o);

   p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_w && addr_w == REG_LIM && !wrap_w) |=> !irq_o);

   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_w && addr_w == REG_LIM && wrap_w) |=> irq_o);

   p_keep_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_w && addr_w == REG_LIM_KEEP && irq_o) |=> irq_o);

   p_counter_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel_i && bus_wr_i && addr_w == REG_CNT) |=> $stable(lim_w));

endmodule

// File: tb/sim_lim_tick_timer.sv
module sim_lim_tick_timer;

   localparam int LSB = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   lim_tick_timer u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .bus_sel_i   (sel),
      .bus_wr_i    (wr),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   function automatic logic [31:0] mk(input logic f, input int v);
      return {f, 21'(v), 10'b0};
   endfunction

   function automatic logic [31:0] fld(input int v);
      return 32'(v) << LSB;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check("R1 irq", 32'(irq), 32'd0);
      bus_read(2'd1, d); check("R1 counter", d, mk(0, 1));
      bus_read(2'd0, d); check("R1 limit", d, 32'd0);
      bus_read(2'd3, d); check("R12 unused read", d, 32'd0);
   endtask

   task automatic t_disabled;
      logic [31:0] d;
      ticks(3);
      bus_read(2'd1, d); check("R7 no count at limit 0", d, mk(0, 1));
      check("R7 irq", 32'(irq), 32'd0);
   endtask

   task automatic t_sequence;
      logic [31:0] d;
      bus_write(2'd0, fld(4));
      bus_read(2'd1, d); check("R5 start at 1", d, mk(0, 1));
      ticks(1); bus_read(2'd1, d); check("R2 step 2", d, mk(0, 2));
      ticks(1); bus_read(2'd1, d); check("R2 step 3", d, mk(0, 3));
      check("R3 irq before wrap", 32'(irq), 32'd0);
      ticks(1); bus_read(2'd1, d); check("R2 R3 wrap to 1 flag", d, mk(1, 1));
      check("R3 irq after wrap", 32'(irq), 32'd1);
   endtask

   task automatic t_read_clear;
      logic [31:0] d;
      bus_read(2'd2, d); check("R11 keep addr word", d, mk(1, 4));
      check("R11 no clear", 32'(irq), 32'd1);
      bus_read(2'd0, d); check("R4 limit word", d, mk(1, 4));
      check("R4 irq cleared", 32'(irq), 32'd0);
      bus_read(2'd0, d); check("R4 flag cleared", d, mk(0, 4));
   endtask

   task automatic t_write_vs_tick;
      logic [31:0] d;
      @(negedge clk);
      tick = 1'b1; sel = 1'b1; wr = 1'b1; addr = 2'd2; wdata = fld(4);
      @(negedge clk);
      tick = 1'b0; sel = 1'b0; wr = 1'b0;
      bus_read(2'd1, d); check("R9 tick dropped", d, mk(0, 1));
   endtask

   task automatic t_counter_ro;
      logic [31:0] d;
      bus_write(2'd1, fld(7));
      bus_read(2'd1, d); check("R8 counter unchanged", d, mk(0, 1));
      bus_read(2'd0, d); check("R8 limit unchanged", d, mk(0, 4));
   endtask

   task automatic t_keep_limit;
      logic [31:0] d;
      ticks(2);
      bus_write(2'd2, fld(10));
      bus_read(2'd1, d); check("R6 count kept", d, mk(0, 3));
      ticks(1); bus_read(2'd1, d); check("R6 counts past old limit", d, mk(0, 4));
      bus_write(2'd2, fld(3));
      bus_read(2'd1, d); check("R6 count kept 2", d, mk(0, 4));
      ticks(1); bus_read(2'd1, d); check("R6 beyond limit wraps", d, mk(1, 1));
      bus_read(2'd0, d); check("R6 new limit", d, mk(1, 3));
   endtask

   task automatic t_restart;
      logic [31:0] d;
      ticks(1);
      bus_read(2'd1, d); check("R5 before restart", d, mk(0, 2));
      bus_write(2'd0, fld(6));
      bus_read(2'd1, d); check("R5 restarted", d, mk(0, 1));
      bus_read(2'd0, d); check("R5 limit loaded", d, mk(0, 6));
   endtask

   task automatic t_set_wins;
      logic [31:0] d;
      ticks(4);
      @(negedge clk);
      tick = 1'b1; sel = 1'b1; wr = 1'b0; addr = 2'd0;
      @(negedge clk);
      tick = 1'b0; sel = 1'b0;
      check("R10 read shows old flag", rdata, mk(0, 6));
      check("R10 set wins", 32'(irq), 32'd1);
      bus_read(2'd1, d); check("R10 flag and wrap", d, mk(1, 1));
      ticks(5);
      check("R10 stays set", 32'(irq), 32'd1);
      bus_read(2'd0, d); check("R10 single clear", d, mk(1, 6));
      check("R10 irq low", 32'(irq), 32'd0);
   endtask

   task automatic t_min_limit;
      logic [31:0] d;
      bus_write(2'd0, fld(2));
      ticks(1);
      bus_read(2'd1, d); check("R2 limit 2 wrap", d, mk(1, 1));
      bus_read(2'd0, d); check("R2 limit 2 clear", d, mk(1, 2));
      ticks(1);
      check("R2 limit 2 again", 32'(irq), 32'd1);
      bus_read(2'd0, d); check("R2 limit 2 read", d, mk(1, 2));
   endtask

   task automatic t_dead_addr;
      logic [31:0] d;
      bus_write(2'd3, fld(9));
      bus_read(2'd0, d); check("R12 limit untouched", d, mk(0, 2));
      bus_read(2'd1, d); check("R12 counter untouched", d, mk(0, 1));
      bus_read(2'd3, d); check("R12 reads zero", d, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_disabled;
      t_sequence;
      t_read_clear;
      t_write_vs_tick;
      t_counter_ro;
      t_keep_limit;
      t_restart;
      t_set_wins;
      t_min_limit;
      t_dead_addr;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule